// File: doc/BRIEF.md
# Receive Character Queue with Delayed Ready

This block buffers received serial characters between a bit-level receiver and a host register interface. The receiver hands over one character, together with its per-character error flags, on a single-cycle push strobe. The host never pops the queue by reading. It issues a pull command, which moves the oldest entry into a holding register that drives the data outputs, and then reads that register as often as it likes. A clear command drops everything that is queued.

The ready indication is held back on purpose. The timer starts when a character lands in an empty queue and counts bit-time ticks from the baud logic. Ready rises once the programmed number of ticks has passed, so one host interrupt can serve a burst of characters. A value of 110, which is ten 11-bit frames, is a sensible setting. Ready also rises at once when the queue becomes full, so that no character is lost while the timer is still counting. The block also reports the number of queued characters and keeps a sticky overrun flag.

Top module: `rx_char_queue`

## Requirements
- R1: After a synchronous active-low reset, count_o is 0, ready_o is 0, overrun_o is 0, and data_char_o and data_flags_o are 0.
- R2: A push while the queue is not full stores {push_flags_i, push_char_i} and raises count_o by one at the next edge. The queue holds 16 entries.
- R3: A pull on a non-empty queue loads the oldest entry into data_char_o/data_flags_o and lowers count_o by one at the next edge. Entries come out in arrival order. The data outputs change only on such a pull, so reading them never consumes an entry.
- R4: A pull on an empty queue has no effect: count_o stays 0 and the data outputs keep their value.
- R5: clear_i empties the queue at the next edge and drops ready_o. It overrides a push or a pull in the same cycle, and the data outputs keep their value.
- R6: With delay_i = D, ready_o rises at the edge that samples the D-th bit_tick_i pulse after the push into the empty queue. A tick in the same cycle as that push is not counted. Cycles without a tick do not advance the count. With D = 0, ready_o rises together with the first character.
- R7: ready_o is 1 whenever count_o is 16, whatever the timer holds.
- R8: Once raised, ready_o stays 1 until the queue becomes empty, and it is 0 while the queue is empty. The delay is measured afresh from the next push into an empty queue.
- R9: A push into a full queue without a pull in the same cycle drops the character, leaves count_o at 16, and sets overrun_o, which holds until ovr_clr_i.
- R10: A push and a pull in the same cycle on a full queue keep count_o at 16, store the new character and do not set overrun_o.
- R11: count_o is a 5-bit field that always equals the number of queued entries and never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Receiver strobe: one character available |
| push_char_i | input | 8 | Received character |
| push_flags_i | input | 3 | Error flags received with the character |
| pull_i | input | 1 | Host command: move the oldest entry to the data outputs |
| clear_i | input | 1 | Host command: empty the queue |
| ovr_clr_i | input | 1 | Host command: clear the overrun flag |
| bit_tick_i | input | 1 | One-cycle pulse per serial bit time |
| delay_i | input | 8 | Ready delay in bit times |
| ready_o | output | 1 | Delayed receive-ready flag |
| count_o | output | 5 | Number of queued entries |
| overrun_o | output | 1 | Sticky overrun flag |
| data_char_o | output | 8 | Character of the last pulled entry |
| data_flags_o | output | 3 | Flags of the last pulled entry |

## Verification
A corrupted read or write pointer shows up on the data outputs at the very next pull as a character that is out of order or repeated, and a count that is off by one shows up at once on count_o and moves the full-queue ready edge. A timer that miscounts moves the rising edge of ready_o by whole tick periods, so the bench sweeps delay values from 0 up to 255 and checks ready_o after every tick and after idle cycles. An overrun decode that is wrong either sets overrun_o on a full-queue swap or fails to drop the extra character, and the bench sees that a cycle later on overrun_o or 16 pulls later on the data outputs.

// File: rtl/rxq_pkg.sv
// rxq_pkg: shared widths and the queue entry type for the receive
// character queue. Assumes 8-bit characters with three error flags.
package rxq_pkg;
    localparam int RXQ_CHAR_W          = 8;
    localparam int RXQ_FLAG_W          = 3;
    localparam int RXQ_DLY_W           = 8;
    localparam int RXQ_DLY_RECOMMENDED = 110;

    typedef struct packed {
        logic [RXQ_FLAG_W-1:0] flags;
        logic [RXQ_CHAR_W-1:0] ch;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// rxq_store: circular entry storage with read and write pointers.
// Assumes the caller only writes when there is room and only reads when
// the queue holds an entry. DEPTH must be at least 2.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       flush,
    input  rxq_entry_t wr_data,
    output rxq_entry_t head
);
    localparam int              PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rxq_entry_t       slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_inc, rd_inc;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_inc = wr_ptr + 1'b1;
            assign rd_inc = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Pointer registers, both returned to slot 0 on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_inc;
            if (rd_en) rd_ptr <= rd_inc;
        end
    end

    // Entry write.
    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_ptr] <= wr_data;
    end

    assign head = slot[rd_ptr];
endmodule

// File: rtl/rxq_level.sv
// rxq_level: decides which commands take effect and keeps the occupancy
// count and the sticky overrun flag. clear overrides push and pull. A
// push into a full queue is accepted only when a pull frees a slot in
// the same cycle.
module rxq_level #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pull_req,
    input  logic             flush,
    input  logic             ovr_clr,
    output logic             do_push,
    output logic             do_pull,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic full, empty, ovr_evt;

    // Command qualification from the current occupancy.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        do_pull = pull_req && !flush && !empty;
        do_push = push_req && !flush && (!full || do_pull);
        ovr_evt = push_req && !flush && full && !do_pull;
    end

    // Next occupancy.
    always_comb begin
        count_next = count;
        if (flush)                   count_next = '0;
        else if (do_push && !do_pull) count_next = count + 1'b1;
        else if (do_pull && !do_push) count_next = count - 1'b1;
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_next;
    end

    // Sticky overrun: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_evt) overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    // R10
    swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pull) |=> $stable(count));
    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !flush && count == FULL_CNT && !pull_req) |=> (overrun && $stable(count)));
    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/rxq_ready_timer.sv
// rxq_ready_timer: counts bit ticks from the push into an empty queue
// and raises ready when the count reaches the programmed delay or the
// queue fills. Ready stays up until the queue empties. The tick counter
// saturates at its maximum.
module rxq_ready_timer #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] delay,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_next,
    output logic             ready
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DLY_W-1:0] elapsed_q, elapsed_n;
    logic             ready_n;

    // Next tick count and next ready value.
    always_comb begin
        elapsed_n = elapsed_q;
        if (count_next == '0)                       elapsed_n = '0;
        else if (count == '0)                       elapsed_n = '0;
        else if (bit_tick && (elapsed_q != '1))     elapsed_n = elapsed_q + 1'b1;
        ready_n = (count_next != '0) &&
                  (ready || (count_next == FULL_CNT) || (elapsed_n >= delay));
    end

    // Timer and ready registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            ready     <= 1'b0;
        end else begin
            elapsed_q <= elapsed_n;
            ready     <= ready_n;
        end
    end

    // R8
    ready_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (count != '0));
    // R7
    full_forces_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT) |-> ready);
    // R8
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && count_next != '0) |=> ready);
endmodule

// File: rtl/rx_char_queue.sv
// rx_char_queue: receive-side character queue with a delayed ready flag.
// Assumes push, pull, clear and tick are single-cycle strobes on clk.
// The host pulls an entry into the data holding register and then reads
// it; reading alone never consumes an entry.
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DLY_W = RXQ_DLY_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [RXQ_CHAR_W-1:0]        push_char_i,
    input  logic [RXQ_FLAG_W-1:0]        push_flags_i,
    input  logic                         pull_i,
    input  logic                         clear_i,
    input  logic                         ovr_clr_i,
    input  logic                         bit_tick_i,
    input  logic [DLY_W-1:0]             delay_i,
    output logic                         ready_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         overrun_o,
    output logic [RXQ_CHAR_W-1:0]        data_char_o,
    output logic [RXQ_FLAG_W-1:0]        data_flags_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             do_push, do_pull;
    logic [CNT_W-1:0] count_next;
    rxq_entry_t       wr_entry, head, data_q;

    assign wr_entry = '{flags: push_flags_i, ch: push_char_i};

    rxq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) level_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (push_i),
        .pull_req   (pull_i),
        .flush      (clear_i),
        .ovr_clr    (ovr_clr_i),
        .do_push    (do_push),
        .do_pull    (do_pull),
        .count      (count_o),
        .count_next (count_next),
        .overrun    (overrun_o)
    );

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_push),
        .rd_en   (do_pull),
        .flush   (clear_i),
        .wr_data (wr_entry),
        .head    (head)
    );

    rxq_ready_timer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DLY_W(DLY_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick_i),
        .delay      (delay_i),
        .count      (count_o),
        .count_next (count_next),
        .ready      (ready_o)
    );

    // Holding register: loaded with the oldest entry on an accepted pull.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (do_pull) data_q <= head;
    end

    assign data_char_o  = data_q.ch;
    assign data_flags_o = data_q.flags;

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_i |=> ($stable(data_char_o) && $stable(data_flags_o)));
    // R4
    empty_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && count_o == '0) |=> ($stable(data_char_o) && count_o == '0 || $past(push_i)));
endmodule

// File: tb/rx_char_queue_tb_top.sv
`timescale 1ns/1ps
module rx_char_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 1'b0, pull_i = 1'b0, clear_i = 1'b0, ovr_clr_i = 1'b0, bit_tick_i = 1'b0;
    logic [7:0] push_char_i = '0;
    logic [2:0] push_flags_i = '0;
    logic [7:0] delay_i = '0;
    logic       ready_o, overrun_o;
    logic [4:0] count_o;
    logic [7:0] data_char_o;
    logic [2:0] data_flags_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_char_queue dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_char_i(push_char_i),
        .push_flags_i(push_flags_i), .pull_i(pull_i), .clear_i(clear_i),
        .ovr_clr_i(ovr_clr_i), .bit_tick_i(bit_tick_i), .delay_i(delay_i),
        .ready_o(ready_o), .count_o(count_o), .overrun_o(overrun_o),
        .data_char_o(data_char_o), .data_flags_o(data_flags_o)
    );

    // One clock: inputs set before the call are sampled at the edge,
    // strobes drop 1 ns later and outputs are then stable for checking.
    task automatic step();
        @(posedge clk);
        #1;
        push_i = 0; pull_i = 0; clear_i = 0; ovr_clr_i = 0; bit_tick_i = 0;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_one(int ch, int fl);
        push_i = 1; push_char_i = 8'(ch); push_flags_i = 3'(fl);
        step();
    endtask

    task automatic pull_one();
        pull_i = 1;
        step();
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int dlist [7] = '{0, 1, 2, 3, 7, 110, 255};
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 ready", ready_o, 0);
        chk("R1 overrun", overrun_o, 0);
        chk("R1 data", data_char_o, 0);
        chk("R1 flags", data_flags_o, 0);

        // R6 delay sweep; a tick with the push is not counted
        foreach (dlist[k]) begin
            int d = dlist[k];
            delay_i = 8'(d);
            bit_tick_i = 1;
            push_one(d, k);
            chk("R2 count after push", count_o, 1);
            chk("R6 ready after push", ready_o, (d == 0) ? 1 : 0);
            for (int i = 1; i <= d; i++) begin
                bit_tick_i = 1;
                step();
                chk("R6 ready after tick", ready_o, (i >= d) ? 1 : 0);
                step();
                chk("R6 ready idle cycle", ready_o, (i >= d) ? 1 : 0);
            end
            pull_one();
            chk("R3 pulled char", data_char_o, d);
            chk("R3 pulled flags", data_flags_o, k);
            chk("R8 count empty", count_o, 0);
            chk("R8 ready empty", ready_o, 0);
        end

        // R7 fill with a long delay
        delay_i = 8'd200;
        for (int i = 0; i < 16; i++) begin
            push_one(8'h40 + i, i);
            chk("R11 count fill", count_o, i + 1);
            chk("R7 ready fill", ready_o, (i == 15) ? 1 : 0);
        end
        // R9 overrun: char dropped, count holds
        push_one(8'hEE, 7);
        chk("R9 overrun set", overrun_o, 1);
        chk("R9 count full", count_o, 16);
        step();
        chk("R9 overrun sticky", overrun_o, 1);
        ovr_clr_i = 1;
        step();
        chk("R9 overrun cleared", overrun_o, 0);
        // R10 swap at full
        pull_i = 1;
        push_one(8'h77, 5);
        chk("R10 count", count_o, 16);
        chk("R10 no overrun", overrun_o, 0);
        chk("R10 oldest out", data_char_o, 8'h40);
        // R3 reading alone does not consume
        repeat (5) step();
        chk("R3 count held", count_o, 16);
        chk("R3 data held", data_char_o, 8'h40);
        for (int k = 1; k < 16; k++) begin
            pull_one();
            chk("R3 order char", data_char_o, 8'h40 + k);
            chk("R3 order flags", data_flags_o, k % 8);
            chk("R8 ready sticky", ready_o, 1);
            chk("R11 count drain", count_o, 16 - k);
        end
        pull_one();
        chk("R10 swapped char", data_char_o, 8'h77);
        chk("R10 swapped flags", data_flags_o, 5);
        chk("R8 ready drop", ready_o, 0);
        // R4 pull on empty
        pull_one();
        chk("R4 count", count_o, 0);
        chk("R4 data", data_char_o, 8'h77);

        // R5 clear overrides push and pull
        delay_i = 8'd0;
        for (int i = 0; i < 5; i++) push_one(i, 0);
        chk("R6 zero delay ready", ready_o, 1);
        clear_i = 1; pull_i = 1;
        push_one(8'h99, 1);
        chk("R5 count", count_o, 0);
        chk("R5 ready", ready_o, 0);
        chk("R5 data kept", data_char_o, 8'h77);
        pull_one();
        chk("R5 nothing left", data_char_o, 8'h77);

        // R8 timer restarts after the queue empties
        delay_i = 8'd3;
        push_one(8'h11, 0);
        bit_tick_i = 1; step();
        bit_tick_i = 1; step();
        pull_one();
        push_one(8'h12, 0);
        bit_tick_i = 1; step();
        bit_tick_i = 1; step();
        chk("R8 restart two ticks", ready_o, 0);
        bit_tick_i = 1; step();
        chk("R8 restart three ticks", ready_o, 1);
        // R5 clear also restarts the timer
        clear_i = 1; step();
        push_one(8'h13, 0);
        bit_tick_i = 1; step();
        bit_tick_i = 1; step();
        chk("R5 timer after clear", ready_o, 0);
        bit_tick_i = 1; step();
        chk("R5 ready after clear", ready_o, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule